// File: doc/BRIEF.md
# Transmit Statistics Counter Bank

This block keeps the transmit-side statistics of a network MAC. The MAC raises a completion event each time it finishes with a frame on the link. The event carries one outcome code: sent correctly, dropped after reaching the configured collision limit, or dropped because a collision arrived after the slot time. The block keeps one saturating counter per outcome. A counter never moves when a frame is fetched from memory, only when its outcome is reported.

Software does not read the counters directly. It issues a command, and the block streams all counters out as 32-bit words at fixed byte offsets through a write port, one word per cycle.

A plain dump leaves the counters as they were. A dump-with-clear freezes the values at the cycle the command is accepted and clears the counters in that same cycle. Events that arrive while the words go out are applied to the cleared counters, so none are lost. A one-cycle done pulse marks the end of a dump. Commands that arrive while a dump is running are dropped.

Top module: `txstat_bank`

## Requirements
- R1: After reset, busy, done and wrValid are low and every counter reads zero in the first dump.
- R2: A completion event with code 2'b01 increments the good-frame counter (dump byte offset 0) by one and leaves the others unchanged.
- R3: A completion event with code 2'b10 increments the collision-limit counter (dump byte offset 4) by one and leaves the others unchanged.
- R4: A completion event with code 2'b11 increments the late-collision counter (dump byte offset 8) by one and leaves the others unchanged.
- R5: Code 2'b00, or evtValid low, changes no counter.
- R6: A counter that holds all ones stays at all ones on further events; it does not wrap.
- R7: An accepted command writes exactly three words, in consecutive cycles starting the cycle after acceptance, at byte addresses 0, 4 and 8 in that order. Each word is zero-extended to 32 bits.
- R8: A dump with cmdClear low leaves the counters unchanged, so a second dump returns the same values.
- R9: A dump with cmdClear high writes the values held at acceptance and clears all counters in the acceptance cycle.
- R10: During a dump with cmdClear high, events in the acceptance cycle or in later cycles are counted on the cleared counters.
- R11: busy is high while words are written. done is high for exactly one cycle, the cycle after the last word, and busy is then low.
- R12: A command presented while busy is high is ignored: it starts no dump and clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Frame completion on the link |
| evtCode | input | 2 | Outcome: 01 good, 10 collision limit, 11 late collision |
| cmdValid | input | 1 | Dump command request |
| cmdClear | input | 1 | With cmdValid: clear counters after capture |
| wrValid | output | 1 | Dump word valid |
| wrAddr | output | ADDR_W | Byte offset of the dump word |
| wrData | output | 32 | Dump word |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The assertions check the shape of every dump on every cycle. The address starts at zero and steps by four up to the last slot, done follows the last word as a single-cycle pulse, and a dump begins only after a command. The counter values themselves can only be shown by the bench's scenarios. Those cover each outcome code, ignored codes, saturation, a clear with events landing in the acceptance cycle and during the write-out, and a second command issued mid-dump.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int NUM_CNT = 3;
  localparam int IDX_W   = $clog2(NUM_CNT);

  typedef enum logic [1:0] {
    OUT_NONE = 2'b00,
    OUT_GOOD = 2'b01,
    OUT_MAXCOL = 2'b10,
    OUT_LATECOL = 2'b11
  } outcome_e;

  typedef struct packed {
    logic             capture;
    logic             clearAll;
    logic [IDX_W-1:0] wordSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         cmdClear,
  output ctrlStrobes_t strobes,
  output logic         wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic         busy,
  output logic         done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CNT - 1);

  logic             busyQ;
  logic             doneQ;
  logic [IDX_W-1:0] idxQ;
  logic             accept;

  assign accept = cmdValid && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      doneQ <= busyQ && (idxQ == LAST_IDX);
      if (accept) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
      end else if (busyQ) begin
        if (idxQ == LAST_IDX) busyQ <= 1'b0;
        else                  idxQ  <= idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capture  = accept;
    strobes.clearAll = accept && cmdClear;
    strobes.wordSel  = idxQ;
  end

  assign wrValid = busyQ;
  assign wrAddr  = ADDR_W'({idxQ, 2'b00});
  assign busy    = busyQ;
  assign done    = doneQ;
endmodule

// File: rtl/txstat_dp.sv
module txstat_dp
  import txstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtValid,
  input  logic [1:0]   evtCode,
  input  ctrlStrobes_t strobes,
  output logic [31:0]  wrData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ  [NUM_CNT];
  logic [CNT_W-1:0] snapQ [NUM_CNT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    assign hit = evtValid && (evtCode == 2'(i + 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i]  <= '0;
        snapQ[i] <= '0;
      end else begin
        if (strobes.capture) snapQ[i] <= cntQ[i];
        if (strobes.clearAll)
          cntQ[i] <= hit ? CNT_W'(1) : '0;
        else if (hit && cntQ[i] != CNT_MAX)
          cntQ[i] <= cntQ[i] + 1'b1;
      end
    end
  end

  always_comb begin
    wrData = '0;
    wrData[CNT_W-1:0] = snapQ[strobes.wordSel];
  end
endmodule

// File: rtl/txstat_bank.sv
module txstat_bank
  import txstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [1:0]        evtCode,
  input  logic              cmdValid,
  input  logic              cmdClear,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              busy,
  output logic              done
);
  ctrlStrobes_t strobes;

  txstat_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdClear(cmdClear),
    .strobes(strobes), .wrValid(wrValid), .wrAddr(wrAddr),
    .busy(busy), .done(done)
  );

  txstat_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtCode(evtCode),
    .strobes(strobes), .wrData(wrData)
  );
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk
  import txstat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              busy,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(4 * (NUM_CNT - 1));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr != LAST_ADDR) |=> (wrValid && wrAddr == $past(wrAddr) + ADDR_W'(4)));

  assert_first_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> (wrAddr == '0));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(wrValid) && $past(wrAddr) == LAST_ADDR && !busy));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_on_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));
endmodule

bind txstat_bank txstat_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .wrValid(wrValid),
  .wrAddr(wrAddr), .busy(busy), .done(done)
);

// File: tb/test_txstat_bank.sv
`timescale 1ns/1ps
module test_txstat_bank;
  localparam int W = 8;
  localparam int AW = 8;
  localparam logic [31:0] SAT = 32'(2**W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [1:0] evtCode = 2'b00;
  logic cmdValid = 1'b0;
  logic cmdClear = 1'b0;
  logic wrValid;
  logic [AW-1:0] wrAddr;
  logic [31:0] wrData;
  logic busy;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [31:0] expv [3];
  logic [31:0] got [3];
  int nWr, nDone, badAddr, cyc, lastWrCyc, doneCyc;

  always #2.5 clk = ~clk;

  txstat_bank #(.CNT_W(W), .ADDR_W(AW)) i_txstat_bank (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtCode(evtCode),
    .cmdValid(cmdValid), .cmdClear(cmdClear), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .done(done)
  );

  always @(negedge clk) begin
    cyc++;
    if (wrValid) begin
      if (nWr < 3 && wrAddr == AW'(4 * nWr)) got[nWr] = wrData;
      else badAddr++;
      nWr++;
      lastWrCyc = cyc;
      if (!busy) badAddr++;
    end
    if (done) begin
      nDone++;
      doneCyc = cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic evt(input logic [1:0] code, input int n);
    for (int k = 0; k < n; k++) begin
      evtValid = 1'b1; evtCode = code;
      @(negedge clk);
      if (code != 2'b00 && expv[code - 1] != SAT) expv[code - 1]++;
    end
    evtValid = 1'b0; evtCode = 2'b00;
  endtask

  task automatic startCmd(input logic clr);
    nWr = 0; nDone = 0; badAddr = 0; doneCyc = 0; lastWrCyc = 0;
    cmdValid = 1'b1; cmdClear = clr;
    @(negedge clk);
    cmdValid = 1'b0; cmdClear = 1'b0;
  endtask

  task automatic finishDump(input string req);
    repeat (5) @(negedge clk);
    chk({req, " R7 word count"}, 32'(nWr), 32'd3);
    chk({req, " R7 address order"}, 32'(badAddr), 32'd0);
    chk({req, " R11 done once"}, 32'(nDone), 32'd1);
    chk({req, " R11 done after last"}, 32'(doneCyc), 32'(lastWrCyc + 1));
  endtask

  task automatic dumpCheck(input string req, input logic clr);
    logic [31:0] snap [3];
    for (int i = 0; i < 3; i++) snap[i] = expv[i];
    startCmd(clr);
    finishDump(req);
    for (int i = 0; i < 3; i++) chk({req, " word"}, got[i], snap[i]);
    if (clr) for (int i = 0; i < 3; i++) expv[i] = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 wrValid", 32'(wrValid), 0);
    dumpCheck("R1 zero dump", 1'b0);
  endtask

  task automatic t_codes();
    evt(2'b01, 3); dumpCheck("R2 good", 1'b0);
    evt(2'b10, 2); dumpCheck("R3 maxcol", 1'b0);
    evt(2'b11, 5); dumpCheck("R4 latecol", 1'b0);
    evt(2'b00, 4);
    evtValid = 1'b0; evtCode = 2'b01; repeat (3) @(negedge clk); evtCode = 2'b00;
    dumpCheck("R5 ignored", 1'b0);
    dumpCheck("R8 repeat dump", 1'b0);
  endtask

  task automatic t_clear();
    dumpCheck("R9 clear dump", 1'b1);
    dumpCheck("R9 after clear", 1'b0);
  endtask

  task automatic t_clearRace();
    logic [31:0] snap [3];
    evt(2'b01, 2); evt(2'b10, 1);
    for (int i = 0; i < 3; i++) snap[i] = expv[i];
    nWr = 0; nDone = 0; badAddr = 0; doneCyc = 0; lastWrCyc = 0;
    cmdValid = 1'b1; cmdClear = 1'b1; evtValid = 1'b1; evtCode = 2'b11;
    @(negedge clk);
    cmdValid = 1'b0; cmdClear = 1'b0; evtCode = 2'b01;
    @(negedge clk);
    evtCode = 2'b10;
    @(negedge clk);
    evtValid = 1'b0; evtCode = 2'b00;
    finishDump("R10 race");
    for (int i = 0; i < 3; i++) chk("R10 captured word", got[i], snap[i]);
    expv[0] = 1; expv[1] = 1; expv[2] = 1;
    dumpCheck("R10 kept events", 1'b0);
  endtask

  task automatic t_busyCmd();
    evt(2'b11, 2);
    nWr = 0; nDone = 0; badAddr = 0; doneCyc = 0; lastWrCyc = 0;
    cmdValid = 1'b1; cmdClear = 1'b0;
    @(negedge clk);
    cmdClear = 1'b1;
    @(negedge clk);
    chk("R11 busy during write", 32'(busy), 1);
    @(negedge clk);
    cmdValid = 1'b0; cmdClear = 1'b0;
    finishDump("R12 busy cmd");
    chk("R11 idle after done", 32'(busy), 0);
    dumpCheck("R12 no clear", 1'b0);
  endtask

  task automatic t_sat();
    evt(2'b10, 260);
    dumpCheck("R6 saturate", 1'b0);
    chk("R6 sat value", got[1], SAT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) expv[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_clear();
    t_clearRace();
    t_busyCmd();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule